// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This block encrypts one 128-bit plaintext block under a 128-bit key. It is built for minimum area. The datapath is one byte wide, and a single substitution-box instance serves both the cipher state and the key schedule. A one-cycle `start` strobe, sampled while the core is idle, captures the plaintext and the key in parallel. From that point the core runs ten rounds on a fixed schedule. The ciphertext then leaves one byte per cycle, qualified by `ct_valid`, with the most significant byte first.

Every round takes 21 cycles in three phases, always in the same order:

- Sixteen cycles each mix one state byte with its round-key byte and substitute the result.
- One cycle permutes the bytes of the state by row rotation.
- Four cycles each mix one column.

During those four column cycles the state path has no use for the substitution box. The key schedule borrows it to substitute the rotated last word of the current round key, and so builds the next round key.

In the tenth round the column slot still takes its four cycles, but the state register is held. The schedule therefore stays uniform while the final round goes unmixed. The last round key is added to each byte as it streams out. The first ciphertext byte appears 211 cycles after the start edge and the last one 226 cycles after it.

Top module: `aes_ser_core`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `ct_valid` and `done` are 0 and `ct_byte` is 0x00.
- R2: For key 0x000102030405060708090a0b0c0d0e0f and plaintext 0x00112233445566778899aabbccddeeff, the sixteen output bytes form 0x69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: Counting the rising edge that samples `start` as edge 0, the first output byte is valid in the cycle after edge 210 (cycle 211). The last byte is valid in cycle 226. `ct_valid` is high for exactly 16 consecutive cycles, and bytes are delivered from the most significant to the least significant.
- R4: `done` is high for exactly one cycle per block, in the cycle of the last output byte (cycle 226).
- R5: A `start` pulse, with any plaintext and key, that arrives while `busy` is 1 has no effect: neither the output bytes nor their timing change.
- R6: `busy` is 1 from cycle 1 through cycle 226 and 0 in cycle 227. A `start` sampled while idle is accepted, including for a block that directly follows a finished one.
- R7: Outside the 16-cycle output window, `ct_valid` is 0 and `ct_byte` is 0x00.
- R8: The round key is expanded on the fly. The key register changes only when a block is loaded or in the last column cycle of a round. The round constant starts at 0x01 and is doubled modulo 0x11B after each round. The result is correct for a second key (key 0x2b7e151628aed2a6abf7158809cf4f3c with plaintext 0x3243f6a8885a308d313198a2e0370734 gives 0x3925841d02dc09fbdc118597196a0b32) and for the all-zero key and plaintext (giving 0x66e94bd4ef8a2c3b884cfa59ca342b2e).
- R9: In the tenth round the state register is not written during the four column cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load strobe; sampled only while idle |
| pt_in | input | 128 | Plaintext block, first byte in bits 127:120 |
| key_in | input | 128 | Cipher key, first byte in bits 127:120 |
| busy | output | 1 | High while a block is in flight |
| ct_byte | output | 8 | Ciphertext byte; 0x00 when not valid |
| ct_valid | output | 1 | Qualifies `ct_byte` |
| done | output | 1 | One-cycle pulse with the last ciphertext byte |

## Verification
The core is run with three key and plaintext pairs:

- Counting patterns with a byte-indexed key show whether the byte order and the row rotation are correct.
- A mixed-bit key and plaintext exercise every branch of the key schedule's round constant.
- All-zero inputs isolate the substitution and constant terms from any data dependence.

Each run also has its window position and length measured, which separates a right answer delivered late from one delivered on time. A further run injects `start` with inverted data, once mid-round and once mid-output. A run straight after another shows that the core returns to idle cleanly.

// File: rtl/aes_ser_pkg.sv
package aes_ser_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SUB   = 3'd1,
    PH_SHIFT = 3'd2,
    PH_MIX   = 3'd3,
    PH_OUT   = 3'd4
  } phase_e;

  // multiply by x modulo x^8 + x^4 + x^3 + x + 1
  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = xtime(aa);
    end
    return acc;
  endfunction

  // field inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int k);
    return (x << k) | (x >> (8 - k));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] v;
    v = ginv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // one column, byte 0 in bits 31:24
  function automatic logic [31:0] mixcol(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    a0 = c[31:24]; a1 = c[23:16]; a2 = c[15:8]; a3 = c[7:0];
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

endpackage

// File: rtl/aes_ser_sbox.sv
module aes_ser_sbox (
  input  logic [7:0] sb_a,
  output logic [7:0] sb_y
);
  import aes_ser_pkg::*;

  always_comb sb_y = sbox(sb_a);

endmodule

// File: rtl/aes_ser_ctrl.sv
module aes_ser_ctrl #(
  parameter int ROUNDS = 10,
  parameter int NBYTES = 16,
  parameter int NCOLS  = 4,
  localparam int IW = $clog2(NBYTES),
  localparam int RW = $clog2(ROUNDS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output aes_ser_pkg::phase_e    phase_q,
  output logic [IW-1:0]          idx_q,
  output logic [RW-1:0]          round_q,
  output logic                   load,
  output logic                   key_commit,
  output logic                   last_round,
  output logic                   busy,
  output logic                   out_valid,
  output logic                   done
);
  import aes_ser_pkg::*;

  logic idx_at_byte_end;
  logic idx_at_col_end;

  assign idx_at_byte_end = (idx_q == IW'(NBYTES - 1));
  assign idx_at_col_end  = (idx_q == IW'(NCOLS - 1));
  assign last_round      = (round_q == RW'(ROUNDS));
  assign load            = (phase_q == PH_IDLE) && start;
  assign key_commit      = (phase_q == PH_MIX) && idx_at_col_end;
  assign busy            = (phase_q != PH_IDLE);
  assign out_valid       = (phase_q == PH_OUT);
  assign done            = out_valid && idx_at_byte_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      round_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SUB;
          idx_q   <= '0;
          round_q <= RW'(1);
        end
        PH_SUB: begin
          if (idx_at_byte_end) begin
            phase_q <= PH_SHIFT;
            idx_q   <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        PH_SHIFT: begin
          phase_q <= PH_MIX;
          idx_q   <= '0;
        end
        PH_MIX: begin
          if (idx_at_col_end) begin
            idx_q <= '0;
            if (last_round) phase_q <= PH_OUT;
            else begin
              phase_q <= PH_SUB;
              round_q <= round_q + 1'b1;
            end
          end else idx_q <= idx_q + 1'b1;
        end
        PH_OUT: begin
          if (idx_at_byte_end) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && start) |=> (phase_q == PH_SUB && idx_q == '0 && round_q == RW'(1)));

  // R5
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SUB && idx_q != '0 && start) |=> (round_q == $past(round_q) && phase_q != PH_IDLE));

  // R3
  out_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OUT && idx_q == '0) |-> ($past(phase_q) == PH_MIX && round_q == RW'(ROUNDS)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/aes_ser_keysched.sv
module aes_ser_keysched #(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KEY_W-1:0] key_in,
  input  logic             mix_en,
  input  logic [1:0]       col,
  input  logic             commit,
  input  logic [7:0]       sb_y,
  output logic [7:0]       lookup_byte,
  output logic [KEY_W-1:0] key_q
);
  import aes_ser_pkg::*;

  logic [23:0]      part_q;
  logic [7:0]       rcon_q;
  logic [31:0]      sub_word;
  logic [KEY_W-1:0] key_next;

  // rotated last word: bytes 1,2,3,0 of w3
  always_comb begin
    unique case (col)
      2'd0:    lookup_byte = key_q[23:16];
      2'd1:    lookup_byte = key_q[15:8];
      2'd2:    lookup_byte = key_q[7:0];
      default: lookup_byte = key_q[31:24];
    endcase
  end

  always_comb begin
    sub_word = {part_q, sb_y} ^ {rcon_q, 24'h0};
    key_next[127:96] = key_q[127:96] ^ sub_word;
    key_next[95:64]  = key_q[95:64]  ^ key_next[127:96];
    key_next[63:32]  = key_q[63:32]  ^ key_next[95:64];
    key_next[31:0]   = key_q[31:0]   ^ key_next[63:32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      part_q <= '0;
      rcon_q <= 8'h01;
    end else if (load) begin
      key_q  <= key_in;
      rcon_q <= 8'h01;
    end else begin
      if (mix_en) part_q <= {part_q[15:0], sb_y};
      if (commit) begin
        key_q  <= key_next;
        rcon_q <= xtime(rcon_q);
      end
    end
  end

  // R8
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !commit) |=> $stable(key_q));

endmodule

// File: rtl/aes_ser_core.sv
module aes_ser_core #(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] pt_in,
  input  logic [127:0] key_in,
  output logic         busy,
  output logic [7:0]   ct_byte,
  output logic         ct_valid,
  output logic         done
);
  import aes_ser_pkg::*;

  localparam int NBYTES = 16;
  localparam int NCOLS  = 4;
  localparam int IW     = $clog2(NBYTES);
  localparam int RW     = $clog2(ROUNDS + 1);

  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  logic [RW-1:0] round_q;
  logic          load, key_commit, last_round;
  logic [127:0]  key_q;
  logic [7:0]    ks_lookup, sb_a, sb_y;
  logic [7:0]    st_q [NBYTES];
  logic [7:0]    kb   [NBYTES];
  logic [127:0]  st_flat;
  logic [1:0]    col;
  logic [31:0]   mc_out;
  logic          sub_phase, mix_phase;

  aes_ser_ctrl #(.ROUNDS(ROUNDS), .NBYTES(NBYTES), .NCOLS(NCOLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phase_q(phase_q), .idx_q(idx_q), .round_q(round_q),
    .load(load), .key_commit(key_commit), .last_round(last_round),
    .busy(busy), .out_valid(ct_valid), .done(done)
  );

  assign sub_phase = (phase_q == PH_SUB);
  assign mix_phase = (phase_q == PH_MIX);
  assign col       = idx_q[1:0];

  aes_ser_keysched #(.KEY_W(128)) u_keys (
    .clk(clk), .rst_n(rst_n), .load(load), .key_in(key_in),
    .mix_en(mix_phase), .col(col), .commit(key_commit),
    .sb_y(sb_y), .lookup_byte(ks_lookup), .key_q(key_q)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_bytes
    assign kb[i] = key_q[127-8*i -: 8];
    assign st_flat[127-8*i -: 8] = st_q[i];
  end

  // the one substitution box, shared by state and key schedule
  assign sb_a = sub_phase ? (st_q[idx_q] ^ kb[idx_q]) : ks_lookup;

  aes_ser_sbox u_sbox (.sb_a(sb_a), .sb_y(sb_y));

  assign mc_out = mixcol({st_q[{col, 2'd0}], st_q[{col, 2'd1}],
                          st_q[{col, 2'd2}], st_q[{col, 2'd3}]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) st_q[i] <= 8'h00;
    end else if (load) begin
      for (int i = 0; i < NBYTES; i++) st_q[i] <= pt_in[127-8*i -: 8];
    end else begin
      unique case (phase_q)
        PH_SUB: st_q[idx_q] <= sb_y;
        PH_SHIFT: begin
          for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
              st_q[r + 4*c] <= st_q[r + 4*((c + r) % 4)];
        end
        PH_MIX: if (!last_round) begin
          st_q[{col, 2'd0}] <= mc_out[31:24];
          st_q[{col, 2'd1}] <= mc_out[23:16];
          st_q[{col, 2'd2}] <= mc_out[15:8];
          st_q[{col, 2'd3}] <= mc_out[7:0];
        end
        default: ;
      endcase
    end
  end

  // last round key is added as each byte leaves
  assign ct_byte = ct_valid ? (st_q[idx_q] ^ kb[idx_q]) : 8'h00;

  // R9
  last_mix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_phase && last_round) |=> $stable(st_flat));

  // R8
  key_only_in_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_phase || phase_q == PH_SHIFT || ct_valid) |=> $stable(key_q));

endmodule

// File: tb/aes_ser_core_bench.sv
`timescale 1ns/1ps
module aes_ser_core_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] pt_in = '0;
  logic [127:0] key_in = '0;
  logic         busy, ct_valid, done;
  logic [7:0]   ct_byte;

  int n_chk  = 0;
  int n_fail = 0;

  // {key, plaintext, ciphertext}
  localparam logic [383:0] VECS [3] = '{
    {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32},
    {128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
  };
  localparam string VTAG [3] = '{"R2", "R8", "R8"};

  always #2.5 clk = ~clk;

  aes_ser_core u_aes_ser_core (
    .clk(clk), .rst_n(rst_n), .start(start), .pt_in(pt_in), .key_in(key_in),
    .busy(busy), .ct_byte(ct_byte), .ct_valid(ct_valid), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // intr: cycle in which a stray start with inverted data is driven (0 = none)
  task automatic run_block(input logic [127:0] k, input logic [127:0] p,
                           input logic [127:0] exp, input int intr, input string tag);
    logic [127:0] got = '0;
    int first = -1, last = -1, nval = 0, ndone = 0, donecyc = -1, nonzero = 0;
    bit busy_ok = 1'b1;
    @(negedge clk);
    key_in = k; pt_in = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0; key_in = '0; pt_in = '0;
    for (int n = 1; n <= 240; n++) begin
      if (ct_valid) begin
        got = {got[119:0], ct_byte};
        if (first < 0) first = n;
        last = n;
        nval++;
      end else if (ct_byte != 8'h00) nonzero++;
      if (done) begin ndone++; donecyc = n; end
      if (n <= 226 && !busy) busy_ok = 1'b0;
      if (n == 227 && busy) busy_ok = 1'b0;
      if (n == intr) begin start = 1'b1; pt_in = ~p; key_in = ~k; end
      else begin start = 1'b0; pt_in = '0; key_in = '0; end
      @(negedge clk);
    end
    check(got == exp, tag, "ciphertext", got, exp);
    check(first == 211, "R3", "first byte cycle", 128'(first), 128'd211);
    check(last == 226, "R3", "last byte cycle", 128'(last), 128'd226);
    check(nval == 16, "R3", "byte count", 128'(nval), 128'd16);
    check(ndone == 1 && donecyc == 226, "R4", "done pulses/cycle",
          128'(ndone * 1000 + donecyc), 128'd1226);
    check(nonzero == 0, "R7", "bytes outside window", 128'(nonzero), 128'd0);
    check(busy_ok, "R6", "busy window 1..226", 128'(busy_ok), 128'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    // R1: reset state, with start pulsed during reset
    start = 1'b1;
    repeat (3) @(negedge clk);
    check({busy, ct_valid, done} == 3'b000, "R1", "flags in reset",
          128'({busy, ct_valid, done}), 128'd0);
    check(ct_byte == 8'h00, "R1", "byte in reset", 128'(ct_byte), 128'd0);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, ct_valid, done} == 3'b000, "R1", "flags after reset",
          128'({busy, ct_valid, done}), 128'd0);

    for (int v = 0; v < 3; v++)
      run_block(VECS[v][383:256], VECS[v][255:128], VECS[v][127:0], 0, VTAG[v]);

    // R5: stray start during rounds, then during output
    run_block(VECS[1][383:256], VECS[1][255:128], VECS[1][127:0], 50, "R5");
    run_block(VECS[0][383:256], VECS[0][255:128], VECS[0][127:0], 215, "R5");
    // R6: a new block directly after the previous one finished
    run_block(VECS[2][383:256], VECS[2][255:128], VECS[2][127:0], 0, "R6");

    report();
    $finish;
  end

endmodule